// File: doc/BRIEF.md
# (1+λ) Evolution Controller with Weighted Fitness

This block sequences a (1+λ) evolutionary search over fixed-length gate genomes. A genome describes a single-row grid of two-input nodes followed by output selectors. Each node carries two source genes and one function gene. The controller keeps a parent genome and builds one candidate at a time from a 16-bit pseudo-random source. While a candidate waits, the controller raises an evaluation request. An external netlist evaluator reads the candidate through the genome read port. It then answers with three counts: hazardous outputs, gates used and faulty outputs.

Each returned triple is turned into a saturating weighted cost. A lower cost is better. The cheapest candidate of a generation becomes the next parent, and ties go to the newer candidate so the search can drift across equal-cost genomes. In the first generation every candidate is drawn at random. In later generations each gene of the parent is redrawn with a programmable probability. The search ends on an iteration cap, on a run of generations with no improvement, or on whichever of the two comes first. The result is a done flag, the best cost, and a flag that marks a hazard-free and functionally correct winner. The configuration inputs must stay stable while a search runs.

Top module: `evo_ctrl`

## Requirements
- R1: A one-cycle `start` in the idle or finished state begins a search, and `busy` is high from the next cycle on. A `start` while `busy` is high has no effect on the running search or its results.
- R2: Gene layout: node j (0..N_NODES-1) owns addresses 3j and 3j+1 (source genes) and 3j+2 (function gene), and output o sits at address 3·N_NODES+o. Every candidate gene is legal: a source gene of node j is below N_IN+j, a function gene is below N_FUNC, and an output gene is below N_IN+N_NODES. In the first generation every gene is drawn at random.
- R3: In every later generation, λ offspring are built only from the current parent. Each gene is redrawn with probability `mut_rate`/256, so a `mut_rate` of 0 gives offspring identical to the parent.
- R4: The cost is k_haz·haz_cnt + k_gate·gate_cnt + k_fault·fault_cnt. It is computed on unsigned values and saturates at 2^24−1.
- R5: A candidate is accepted when its cost is less than or equal to the best cost so far, which starts at the parent's cost, or at 2^24−1 in the first generation. At generation close the last accepted candidate becomes the parent, read back with `rd_sel`=1, and `best_fit` reports its cost. `best_fit` never rises during a search.
- R6: `eval_req` is high while a candidate waits and stays high until `eval_ack`. The counts are taken in the cycle `eval_ack` is high, and `eval_req` is low in the next cycle.
- R7: At generation close the stagnation count clears when `best_fit` strictly decreased. Otherwise it increases by one.
- R8: With `cap_en`, the search stops once the completed generation count reaches `max_gen`. With `stall_en`, it stops once the stagnation count reaches `stall_limit`. With both set it stops on either. With neither set, the cap applies. At least one generation always runs.
- R9: When the search ends, `done` is high and `busy` and `eval_req` are low until the next `start`. `gen_count` equals the completed generations. `best_valid` is high exactly when the parent's hazard and fault counts were both zero.
- R10: After reset the block is idle: `busy`, `done` and `eval_req` are low, `best_fit` is 2^24−1 and `gen_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (idle or finished state only) |
| mut_rate | input | 8 | Per-gene redraw probability in 1/256 steps |
| seed | input | 16 | Random source seed loaded at start (0 selects a built-in value) |
| k_haz | input | 8 | Weight of the hazard count |
| k_gate | input | 8 | Weight of the gate count |
| k_fault | input | 8 | Weight of the faulty-output count |
| cap_en | input | 1 | Enable the iteration cap |
| stall_en | input | 1 | Enable the stagnation stop |
| max_gen | input | 16 | Iteration cap in generations |
| stall_limit | input | 16 | Generations without improvement that end the search |
| eval_req | output | 1 | Candidate ready for evaluation |
| eval_ack | input | 1 | Evaluation result valid on the count inputs |
| haz_cnt | input | 16 | Hazardous outputs of the candidate |
| gate_cnt | input | 16 | Gates used by the candidate |
| fault_cnt | input | 16 | Faulty outputs of the candidate |
| rd_sel | input | 1 | Read port source: 0 candidate, 1 parent |
| rd_addr | input | 5 | Gene address |
| rd_data | output | 4 | Gene value (0 for an address past the genome) |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished |
| best_fit | output | 24 | Cost of the current parent |
| best_valid | output | 1 | Parent has zero hazard and fault counts |
| gen_count | output | 16 | Completed generations |

## Verification
The iteration cap and the stagnation stop can both become true in the same generation-close cycle. That cycle also updates the parent and the stagnation count. The bench provokes this with constant counts: the first generation improves on the start value, and every later one stalls. It sets `stall_limit` one below `max_gen`, so both conditions mature together. It judges the outcome by requiring `done` after exactly `max_gen` generations, with no further evaluation request, and by the final cost, validity and parent genome that its own model predicts. Further runs separate the two stops, use neither enable, and give ties and saturated costs so the acceptance rule decides at the boundary.

// File: rtl/evo_pkg.sv
`timescale 1ns/1ps
// Package evo_pkg
// Shared constants and the sequencing state type of the evolution controller.
package evo_pkg;
    localparam int FIT_W = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUILD,
        ST_EVAL,
        ST_CLOSE,
        ST_DONE
    } evo_state_t;
endpackage

// File: rtl/evo_lfsr.sv
`timescale 1ns/1ps
// Module evo_lfsr
// 16-bit Galois shift register used as the random source for gene draws.
// Assumes: a zero seed is replaced by SEED_DEF so the register never locks up.
module evo_lfsr #(
    parameter logic [15:0] SEED_DEF = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] seed,
    input  logic        step,
    output logic [15:0] value
);
    localparam logic [15:0] TAPS = 16'hB400;

    // Load a seed at search start, advance one step per drawn gene.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= SEED_DEF;
        end else if (load) begin
            value <= (seed == 16'h0) ? SEED_DEF : seed;
        end else if (step) begin
            value <= {1'b0, value[15:1]} ^ (value[0] ? TAPS : 16'h0);
        end
    end
endmodule

// File: rtl/evo_fitness.sv
`timescale 1ns/1ps
// Module evo_fitness
// Combinational weighted cost of one candidate, saturated to FIT_W bits.
// Assumes: all weights and counts are unsigned.
module evo_fitness #(
    parameter int CNT_W = 16,
    parameter int W_W   = 8,
    parameter int FIT_W = 24
) (
    input  logic [W_W-1:0]   k_haz,
    input  logic [W_W-1:0]   k_gate,
    input  logic [W_W-1:0]   k_fault,
    input  logic [CNT_W-1:0] haz,
    input  logic [CNT_W-1:0] gates,
    input  logic [CNT_W-1:0] fault,
    output logic [FIT_W-1:0] fit
);
    localparam int PW = CNT_W + W_W;
    localparam int SW = PW + 2;

    logic [SW-1:0] sum;

    // Full-width sum of the three weighted terms.
    always_comb begin
        sum = SW'(k_haz) * SW'(haz) + SW'(k_gate) * SW'(gates) + SW'(k_fault) * SW'(fault);
    end

    generate
        if (SW > FIT_W) begin : g_sat
            // Clamp to the largest representable cost.
            always_comb begin
                fit = (sum > SW'({FIT_W{1'b1}})) ? {FIT_W{1'b1}} : sum[FIT_W-1:0];
            end
        end else begin : g_wide
            // Sum always fits: widen only.
            always_comb begin
                fit = FIT_W'(sum);
            end
        end
    endgenerate
endmodule

// File: rtl/evo_gene_draw.sv
`timescale 1ns/1ps
// Module evo_gene_draw
// Decides whether the gene at one address is redrawn and produces the legal
// replacement value. Source genes of node j draw from [0, N_IN+j), function
// genes from [0, N_FUNC), output genes from [0, N_IN+N_NODES).
// Assumes: the random word is fresh for every gene.
module evo_gene_draw #(
    parameter int N_IN    = 4,
    parameter int N_NODES = 8,
    parameter int N_FUNC  = 7,
    parameter int GW      = 4,
    parameter int AW      = 5
) (
    input  logic [AW-1:0] idx,
    input  logic [GW-1:0] old_gene,
    input  logic [15:0]   rnd,
    input  logic [7:0]    rate,
    input  logic          force_draw,
    output logic [GW-1:0] new_gene
);
    localparam int NODE_GENES = 3 * N_NODES;
    localparam int N_SIG      = N_IN + N_NODES;
    localparam int RW         = $clog2(N_SIG + N_FUNC + 1);
    localparam int PRW        = RW + 8;

    logic [AW-1:0]  node_v;
    logic [AW-1:0]  slot_v;
    logic [RW-1:0]  range_v;
    logic [PRW-1:0] prod;
    logic [PRW-1:0] scaled;
    logic           hit;

    // Legal value range of the gene at this address.
    always_comb begin
        node_v = idx / AW'(3);
        slot_v = idx % AW'(3);
        if (32'(idx) < NODE_GENES) begin
            if (slot_v == AW'(2)) range_v = RW'(N_FUNC);
            else                  range_v = RW'(N_IN) + RW'(node_v);
        end else begin
            range_v = RW'(N_SIG);
        end
    end

    // Scale the low random byte into the range and pick old or new value.
    always_comb begin
        prod     = PRW'(rnd[7:0]) * PRW'(range_v);
        scaled   = prod >> 8;
        hit      = force_draw || (rnd[15:8] < rate);
        new_gene = hit ? scaled[GW-1:0] : old_gene;
    end
endmodule

// File: rtl/evo_ctrl.sv
`timescale 1ns/1ps
// Module evo_ctrl
// Top of the (1+lambda) evolution controller. Builds candidates one gene per
// cycle, requests an external evaluation of each, keeps the cheapest candidate
// (later wins a tie), promotes it at generation close and stops on the
// iteration cap, the stagnation limit, or either.
// Assumes: configuration inputs are held stable while busy is high.
module evo_ctrl
    import evo_pkg::*;
#(
    parameter int          N_IN     = 4,
    parameter int          N_NODES  = 8,
    parameter int          N_FUNC   = 7,
    parameter int          N_OUT    = 2,
    parameter int          LAMBDA   = 4,
    parameter int          CNT_W    = 16,
    parameter int          W_W      = 8,
    parameter int          GEN_W    = 16,
    parameter logic [15:0] SEED_DEF = 16'hACE1,
    localparam int NG_TOT = 3 * N_NODES + N_OUT,
    localparam int N_SIG  = N_IN + N_NODES,
    localparam int GW     = $clog2((N_SIG > N_FUNC) ? N_SIG : N_FUNC),
    localparam int AW     = $clog2(NG_TOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       mut_rate,
    input  logic [15:0]      seed,
    input  logic [W_W-1:0]   k_haz,
    input  logic [W_W-1:0]   k_gate,
    input  logic [W_W-1:0]   k_fault,
    input  logic             cap_en,
    input  logic             stall_en,
    input  logic [GEN_W-1:0] max_gen,
    input  logic [GEN_W-1:0] stall_limit,
    output logic             eval_req,
    input  logic             eval_ack,
    input  logic [CNT_W-1:0] haz_cnt,
    input  logic [CNT_W-1:0] gate_cnt,
    input  logic [CNT_W-1:0] fault_cnt,
    input  logic             rd_sel,
    input  logic [AW-1:0]    rd_addr,
    output logic [GW-1:0]    rd_data,
    output logic             busy,
    output logic             done,
    output logic [FIT_W-1:0] best_fit,
    output logic             best_valid,
    output logic [GEN_W-1:0] gen_count
);
    localparam int          CW       = (LAMBDA > 1) ? $clog2(LAMBDA) : 1;
    localparam logic [FIT_W-1:0] FIT_MAX = {FIT_W{1'b1}};

    evo_state_t       state;
    logic [AW-1:0]    gidx;
    logic [CW-1:0]    cidx;
    logic [GEN_W-1:0] gen_cnt;
    logic [GEN_W-1:0] stall_cnt;
    logic [FIT_W-1:0] run_fit;
    logic             first_gen;
    logic             accepted;
    logic             run_valid;

    logic [GW-1:0] cand   [NG_TOT];
    logic [GW-1:0] gbest  [NG_TOT];
    logic [GW-1:0] parent [NG_TOT];

    logic [15:0]      rnd;
    logic [GW-1:0]    new_gene;
    logic [FIT_W-1:0] cand_fit;
    logic             start_ok;
    logic             take;
    logic             build_last;
    logic             cand_last;
    logic [GEN_W-1:0] gen_next;
    logic [GEN_W-1:0] stall_next;
    logic             improve;
    logic             stop_now;

    // Random source for all gene draws.
    evo_lfsr #(.SEED_DEF(SEED_DEF)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_ok),
        .seed  (seed),
        .step  (state == ST_BUILD),
        .value (rnd)
    );

    // Per-gene redraw decision and legal replacement value.
    evo_gene_draw #(
        .N_IN    (N_IN),
        .N_NODES (N_NODES),
        .N_FUNC  (N_FUNC),
        .GW      (GW),
        .AW      (AW)
    ) u_draw (
        .idx        (gidx),
        .old_gene   (parent[gidx]),
        .rnd        (rnd),
        .rate       (mut_rate),
        .force_draw (first_gen),
        .new_gene   (new_gene)
    );

    // Weighted cost of the candidate under evaluation.
    evo_fitness #(
        .CNT_W (CNT_W),
        .W_W   (W_W),
        .FIT_W (FIT_W)
    ) u_fit (
        .k_haz   (k_haz),
        .k_gate  (k_gate),
        .k_fault (k_fault),
        .haz     (haz_cnt),
        .gates   (gate_cnt),
        .fault   (fault_cnt),
        .fit     (cand_fit)
    );

    // Control decode: start acceptance, acceptance test, loop ends, stop rule.
    always_comb begin
        start_ok   = start && ((state == ST_IDLE) || (state == ST_DONE));
        take       = (state == ST_EVAL) && eval_ack && (cand_fit <= run_fit);
        build_last = (gidx == AW'(NG_TOT - 1));
        cand_last  = (cidx == CW'(LAMBDA - 1));
        gen_next   = gen_cnt + GEN_W'(1);
        improve    = (run_fit < best_fit);
        if (improve)                            stall_next = '0;
        else if (stall_cnt == {GEN_W{1'b1}})    stall_next = stall_cnt;
        else                                    stall_next = stall_cnt + GEN_W'(1);
        stop_now   = ((cap_en || !stall_en) && (gen_next >= max_gen))
                  || (stall_en && (stall_next >= stall_limit));
    end

    // Main sequencer: build, evaluate, close generation, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            gidx       <= '0;
            cidx       <= '0;
            gen_cnt    <= '0;
            stall_cnt  <= '0;
            best_fit   <= FIT_MAX;
            run_fit    <= FIT_MAX;
            first_gen  <= 1'b1;
            accepted   <= 1'b0;
            run_valid  <= 1'b0;
            best_valid <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start_ok) begin
                        state      <= ST_BUILD;
                        gidx       <= '0;
                        cidx       <= '0;
                        gen_cnt    <= '0;
                        stall_cnt  <= '0;
                        best_fit   <= FIT_MAX;
                        run_fit    <= FIT_MAX;
                        first_gen  <= 1'b1;
                        accepted   <= 1'b0;
                        run_valid  <= 1'b0;
                        best_valid <= 1'b0;
                    end
                end
                ST_BUILD: begin
                    if (build_last) state <= ST_EVAL;
                    else            gidx  <= gidx + AW'(1);
                end
                ST_EVAL: begin
                    if (eval_ack) begin
                        if (take) begin
                            run_fit   <= cand_fit;
                            accepted  <= 1'b1;
                            run_valid <= (haz_cnt == '0) && (fault_cnt == '0);
                        end
                        if (cand_last) begin
                            state <= ST_CLOSE;
                        end else begin
                            state <= ST_BUILD;
                            cidx  <= cidx + CW'(1);
                            gidx  <= '0;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (accepted) best_valid <= run_valid;
                    best_fit  <= run_fit;
                    stall_cnt <= stall_next;
                    gen_cnt   <= gen_next;
                    accepted  <= 1'b0;
                    first_gen <= 1'b0;
                    cidx      <= '0;
                    gidx      <= '0;
                    state     <= stop_now ? ST_DONE : ST_BUILD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Candidate store: one freshly drawn gene per build cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NG_TOT; i++) cand[i] <= '0;
        end else if (state == ST_BUILD) begin
            cand[gidx] <= new_gene;
        end
    end

    // Generation-best store: snapshot of the latest accepted candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NG_TOT; i++) gbest[i] <= '0;
        end else if (take) begin
            for (int i = 0; i < NG_TOT; i++) gbest[i] <= cand[i];
        end
    end

    // Parent store: promoted at generation close when anything was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NG_TOT; i++) parent[i] <= '0;
        end else if ((state == ST_CLOSE) && accepted) begin
            for (int i = 0; i < NG_TOT; i++) parent[i] <= gbest[i];
        end
    end

    // Genome read port and status outputs.
    always_comb begin
        if (32'(rd_addr) < NG_TOT) rd_data = rd_sel ? parent[rd_addr] : cand[rd_addr];
        else                       rd_data = '0;
        busy      = (state == ST_BUILD) || (state == ST_EVAL) || (state == ST_CLOSE);
        done      = (state == ST_DONE);
        eval_req  = (state == ST_EVAL);
        gen_count = gen_cnt;
    end
endmodule

// File: rtl/evo_checker.sv
`timescale 1ns/1ps
// Module evo_checker
// Temporal properties of the evolution controller, bound into evo_ctrl.
// Assumes: configuration inputs are stable while busy is high.
module evo_checker #(
    parameter int GEN_W = 16,
    parameter int FIT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             eval_req,
    input logic             eval_ack,
    input logic [FIT_W-1:0] best_fit,
    input logic [GEN_W-1:0] gen_count,
    input logic [GEN_W-1:0] stall_cnt,
    input logic [GEN_W-1:0] max_gen,
    input logic             cap_en,
    input logic             stall_en
);
    // Request held until acknowledged.
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_req && !eval_ack) |=> eval_req);

    // Request withdrawn after the acknowledge cycle.
    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_req && eval_ack) |=> !eval_req);

    // Best cost never rises inside one search.
    assert_best_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (best_fit <= $past(best_fit)));

    // Stagnation count cleared on a strict improvement at generation close.
    assert_stall_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (best_fit < $past(best_fit))) |-> (stall_cnt == '0));

    // Cap bounds the number of generations while the search runs.
    assert_cap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cap_en || !stall_en)) |-> ((gen_count < max_gen) || (gen_count == '0)));

    // Finished state excludes activity.
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !eval_req));
endmodule

bind evo_ctrl evo_checker #(.GEN_W(GEN_W), .FIT_W(evo_pkg::FIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .eval_req  (eval_req),
    .eval_ack  (eval_ack),
    .best_fit  (best_fit),
    .gen_count (gen_count),
    .stall_cnt (stall_cnt),
    .max_gen   (max_gen),
    .cap_en    (cap_en),
    .stall_en  (stall_en)
);

// File: tb/tb_evo_ctrl.sv
`timescale 1ns/1ps
// Bench for evo_ctrl: seeded random counts plus directed termination and
// saturation cases, checked against a model of selection and stopping.
module tb_evo_ctrl;
    localparam int NG  = 26;
    localparam int LAM = 4;
    localparam logic [23:0] FMAX = 24'hFFFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  mut_rate = '0;
    logic [15:0] seed = 16'h1234;
    logic [7:0]  k_haz = '0, k_gate = '0, k_fault = '0;
    logic        cap_en = 1'b0, stall_en = 1'b0;
    logic [15:0] max_gen = '0, stall_limit = '0;
    logic        eval_req;
    logic        eval_ack = 1'b0;
    logic [15:0] haz_cnt = '0, gate_cnt = '0, fault_cnt = '0;
    logic        rd_sel = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [3:0]  rd_data;
    logic        busy, done, best_valid;
    logic [23:0] best_fit;
    logic [15:0] gen_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    evo_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mut_rate(mut_rate), .seed(seed),
        .k_haz(k_haz), .k_gate(k_gate), .k_fault(k_fault), .cap_en(cap_en),
        .stall_en(stall_en), .max_gen(max_gen), .stall_limit(stall_limit),
        .eval_req(eval_req), .eval_ack(eval_ack), .haz_cnt(haz_cnt),
        .gate_cnt(gate_cnt), .fault_cnt(fault_cnt), .rd_sel(rd_sel),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
        .best_fit(best_fit), .best_valid(best_valid), .gen_count(gen_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [23:0] fit_ref(input int kh, kg, kf, nh, ng, nf);
        longint s;
        s = longint'(kh) * nh + longint'(kg) * ng + longint'(kf) * nf;
        return (s > longint'(FMAX)) ? FMAX : s[23:0];
    endfunction

    // Legal bound of the gene at address a (R2 layout).
    function automatic int gene_limit(input int a);
        if (a < 24) return ((a % 3) == 2) ? 7 : 4 + a / 3;
        return 12;
    endfunction

    task automatic read_genome(input bit sel, output int g[NG]);
        rd_sel = sel;
        for (int a = 0; a < NG; a++) begin
            rd_addr = 5'(a);
            #0.5;
            g[a] = int'(rd_data);
        end
    endtask

    task automatic run_search(input int rate, kh, kg, kf, cap, stl, maxg, stlim, cmode, poke);
        int  par[NG], win[NG], cg[NG], pg[NG];
        int  cand_i, mgen, mstall, cyc, nh, ng, nf, bad;
        logic [23:0] mbest, run, f;
        bit  mvalid, rvalid, acc, mstop, seen_done;
        @(negedge clk);
        mut_rate = 8'(rate); k_haz = 8'(kh); k_gate = 8'(kg); k_fault = 8'(kf);
        cap_en = cap[0]; stall_en = stl[0]; max_gen = 16'(maxg); stall_limit = 16'(stlim);
        seed = 16'($urandom);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R1 busy after start", busy, 1);
        for (int a = 0; a < NG; a++) par[a] = 0;
        mbest = FMAX; run = FMAX; mgen = 0; mstall = 0; mvalid = 0; acc = 0; mstop = 0;
        rvalid = 0; cand_i = 0; cyc = 0; seen_done = 0;
        while (!seen_done && cyc < 20000) begin
            if (done) begin
                seen_done = 1;
            end else if (eval_req) begin
                if (mstop) check(0, "R8 evaluation after predicted stop", mgen, maxg);
                read_genome(1'b0, cg);
                bad = 0;
                for (int a = 0; a < NG; a++) if (cg[a] >= gene_limit(a)) bad++;
                check(bad == 0, "R2 illegal genes", bad, 0);
                if (mgen > 0) begin
                    read_genome(1'b1, pg);
                    bad = 0;
                    for (int a = 0; a < NG; a++) if (pg[a] != par[a]) bad++;
                    check(bad == 0, "R5 parent promoted", bad, 0);
                    if (rate == 0) begin
                        bad = 0;
                        for (int a = 0; a < NG; a++) if (cg[a] != par[a]) bad++;
                        check(bad == 0, "R3 zero-rate offspring equals parent", bad, 0);
                    end
                end
                case (cmode)
                    0: begin nh = $urandom_range(0, 3); ng = $urandom_range(0, 3); nf = $urandom_range(0, 3); end
                    1: begin nh = 65535; ng = 65535; nf = 65535; end
                    2: begin nh = 0; ng = 5; nf = 0; end
                    default: begin nh = $urandom_range(0, 40000); ng = $urandom_range(0, 40000); nf = $urandom_range(0, 40000); end
                endcase
                f = fit_ref(kh, kg, kf, nh, ng, nf);
                if (f <= run) begin
                    run = f; acc = 1; rvalid = (nh == 0) && (nf == 0);
                    for (int a = 0; a < NG; a++) win[a] = cg[a];
                end
                @(negedge clk);
                haz_cnt = 16'(nh); gate_cnt = 16'(ng); fault_cnt = 16'(nf); eval_ack = 1'b1;
                @(negedge clk);
                eval_ack = 1'b0;
                check(!eval_req, "R6 request drops after ack", eval_req, 0);
                cand_i++;
                if (cand_i == LAM) begin
                    if (acc) begin
                        for (int a = 0; a < NG; a++) par[a] = win[a];
                        mvalid = rvalid;
                    end
                    if (run < mbest) mstall = 0; else mstall++;
                    mbest = run; mgen++; cand_i = 0; acc = 0;
                    mstop = ((cap != 0 || stl == 0) && mgen >= maxg) || (stl != 0 && mstall >= stlim);
                end
                if (poke != 0 && mgen == 0 && cand_i == 1) begin
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    check(busy, "R1 start while busy ignored", busy, 1);
                end
            end
            if (!seen_done) begin
                @(negedge clk);
                cyc++;
            end
        end
        if (!seen_done) begin
            check(0, "watchdog: search did not finish", cyc, 20000);
        end else begin
            check(mstop, "R8 stop generation", mgen, maxg);
            check(gen_count == 16'(mgen), "R9 gen_count", gen_count, mgen);
            check(best_fit == mbest, "R4 R5 best_fit", best_fit, mbest);
            check(best_valid == mvalid, "R9 best_valid", best_valid, mvalid);
            check(!busy && !eval_req, "R9 idle when done", busy, 0);
            read_genome(1'b1, pg);
            bad = 0;
            for (int a = 0; a < NG; a++) if (pg[a] != par[a]) bad++;
            check(bad == 0, "R5 final parent genome", bad, 0);
            repeat (3) @(negedge clk);
            check(done && !busy, "R9 done held", done, 1);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!busy && !done && !eval_req, "R10 idle after reset", busy, 0);
        check(best_fit == FMAX, "R10 best_fit reset", best_fit, FMAX);
        check(gen_count == 0, "R10 gen_count reset", gen_count, 0);
        // R3 zero rate, cap only, random small counts (ties)
        run_search(0, 3, 1, 5, 1, 0, 3, 0, 0, 0);
        // R1 start ignored while busy; both stops enabled, random mutation
        run_search(60, 2, 1, 4, 1, 1, 6, 2, 0, 1);
        // R4 saturation: every cost clamps, ties at the maximum
        run_search(128, 255, 255, 255, 1, 0, 2, 0, 1, 0);
        // R7 R8 stagnation only
        run_search(10, 1, 1, 1, 0, 1, 2, 3, 2, 0);
        // R8 cap and stagnation mature in the same close
        run_search(30, 1, 1, 1, 1, 1, 4, 3, 2, 0);
        // R8 neither enabled falls back to the cap; wide counts
        run_search(200, 200, 100, 255, 0, 0, 2, 0, 3, 0);
        // R8 zero cap still runs one generation
        run_search(0, 1, 2, 3, 1, 0, 0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Global watchdog: counts as a failed check and still reports.
    initial begin
        wait (cycles >= 190000);
        checks++;
        errors++;
        $display("FAIL watchdog global timeout actual=%0d expected=%0d", cycles, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule